// File: doc/BRIEF.md
# DRAM Self-Refresh Entry Sequencer

This control unit sits ahead of a DRAM command scheduler. It owns the memory clock-enable and a small command request bus. It brings the memory up after a power-up start pulse, either by running a full initialization or by skipping it. Skipping it keeps the contents that survived battery-backed operation. Once the memory is up, it grants the scheduler normal traffic through a ready flag.

Self-refresh can start from two sources. One is a hardware interrupt line, used when a configuration enable allows it; in that case the line serves no other purpose. The other is a software force bit. On either trigger the block withdraws ready and waits for outstanding requests to drain. It then precharges all banks, issues self-refresh entry and drops clock enable. It stays in self-refresh, ignoring further triggers, until an explicit exit request arrives. It then raises clock enable, issues the exit command and waits a programmable number of cycles before granting traffic again.

Top module: `dram_sr_sequencer`

## Requirements
- R1: After reset, and until a `pwr_start` pulse, `dram_cke` is low, `dram_cmd` is NOP (code 0) and `traffic_ready` is low.
- R2: With `cfg_init_bypass` low at `pwr_start`, `dram_cke` rises on the next cycle. The commands on the following cycles are then, in order: INIT_WAIT cycles of NOP, one precharge-all (code 1), MRS_COUNT mode-register loads (code 4) and REF_COUNT refreshes (code 5). `traffic_ready` rises on the cycle after the last refresh.
- R3: With `cfg_init_bypass` high at `pwr_start`, `dram_cke` rises and exactly BYPASS_WAIT (default 200) cycles of NOP follow with `traffic_ready` low. No other command is issued before `traffic_ready` rises.
- R4: While `cfg_irq_sr_en` is high, a rising edge on `irq_out_in` seen while ready starts self-refresh entry; `traffic_ready` falls 3 cycles after the line is first sampled high (two synchronizer stages plus edge detection). While `cfg_irq_sr_en` is low, the line has no effect.
- R5: A rising edge of `cfg_force_sr` while ready starts self-refresh entry, and `traffic_ready` falls on the next cycle.
- R6: From the cycle `traffic_ready` falls, NOP is issued for as long as `busy_in` is sampled high, and for at least one cycle.
- R7: After the drain, exactly one precharge-all (code 1) is issued, then self-refresh entry (code 2), and `dram_cke` is low on the cycle after the entry command.
- R8: While in self-refresh, toggling `irq_out_in` or `cfg_force_sr` leaves `dram_cke` low, `dram_cmd` NOP and `traffic_ready` low. Only `sr_exit_req` or a reset leaves the state.
- R9: A `sr_exit_req` pulse in self-refresh raises `dram_cke` on the next cycle together with self-refresh exit (code 3). Exactly `cfg_exit_dly` cycles of NOP follow, and then `traffic_ready` rises; a delay of 0 raises ready on the cycle after the exit command.
- R10: One assertion of `irq_out_in` or `cfg_force_sr` causes exactly one entry: holding it high through self-refresh and exit does not cause a second entry.
- R11: Whenever `traffic_ready` is high, `dram_cke` is high and `dram_cmd` is NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_irq_sr_en | input | 1 | Lets the interrupt line start self-refresh |
| cfg_force_sr | input | 1 | Software force bit; its rising edge starts self-refresh |
| cfg_init_bypass | input | 1 | Skip initialization at power-up (sampled with `pwr_start`) |
| cfg_exit_dly | input | DLY_W | Cycles from exit command to ready |
| irq_out_in | input | 1 | Asynchronous interrupt-out line |
| pwr_start | input | 1 | Power-up start pulse |
| sr_exit_req | input | 1 | Request to leave self-refresh |
| busy_in | input | 1 | Scheduler still has outstanding requests |
| dram_cke | output | 1 | Memory clock enable |
| dram_cmd | output | 3 | Command request: 0 NOP, 1 precharge-all, 2 SR entry, 3 SR exit, 4 mode load, 5 refresh |
| traffic_ready | output | 1 | Normal traffic may be issued |

## Verification
Six properties are checked on every cycle. They cover: no command other than NOP while clock enable is low, and a quiet command bus with clock enable high while ready. They also cover that self-refresh entry follows a precharge-all, that clock enable drops right after entry, that clock enable only rises after an exit request or a power-up pulse, and that the exit command is issued only when leaving a low clock enable. The following can only be shown by the bench's scenarios: the exact lengths of the initialization and bypass waits, the trigger latencies, the drain length for a given busy pattern, the programmed exit delay, and the one-entry-per-assertion rule.

// File: rtl/srq_pkg.sv
package srq_pkg;
  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_PREA = 3'd1,
    CMD_SRE  = 3'd2,
    CMD_SRX  = 3'd3,
    CMD_MRS  = 3'd4,
    CMD_REF  = 3'd5
  } dram_cmd_e;

  typedef enum logic [3:0] {
    ST_OFF, ST_CKE_WAIT, ST_INIT_PRE, ST_INIT_MRS, ST_INIT_REF, ST_READY,
    ST_DRAIN, ST_SR_PRE, ST_SR_ENTER, ST_SELF_REF, ST_SR_EXIT, ST_EXIT_WAIT
  } seq_state_e;
endpackage

// File: rtl/srq_sync_rise.sv
module srq_sync_rise #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic rise
);
  logic sync_out;
  logic prev_q;

  generate
    if (STAGES == 0) begin : g_direct
      assign sync_out = d;
    end else begin : g_sync
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          chain_q <= '0;
        end else begin
          chain_q[0] <= d;
          for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
        end
      end
      assign sync_out = chain_q[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_out;
  end

  assign rise = sync_out & ~prev_q;
endmodule

// File: rtl/srq_timer.sv
module srq_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/srq_seq_fsm.sv
module srq_seq_fsm
  import srq_pkg::*;
#(
  parameter int INIT_WAIT   = 16,
  parameter int BYPASS_WAIT = 200,
  parameter int MRS_COUNT   = 4,
  parameter int REF_COUNT   = 2,
  parameter int DLY_W       = 4,
  parameter int CNT_W       = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwr_start,
  input  logic             bypass,
  input  logic             trig,
  input  logic             busy,
  input  logic             exit_req,
  input  logic [DLY_W-1:0] exit_dly,
  input  logic             tmr_zero,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             cke,
  output dram_cmd_e        cmd,
  output logic             ready
);
  seq_state_e st_q, st_n;
  logic       byp_q;

  always_comb begin
    st_n     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (st_q)
      ST_OFF: if (pwr_start) begin
        st_n     = ST_CKE_WAIT;
        tmr_load = 1'b1;
        tmr_val  = bypass ? CNT_W'(BYPASS_WAIT - 1) : CNT_W'(INIT_WAIT - 1);
      end
      ST_CKE_WAIT: if (tmr_zero) st_n = byp_q ? ST_READY : ST_INIT_PRE;
      ST_INIT_PRE: begin
        st_n     = ST_INIT_MRS;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(MRS_COUNT - 1);
      end
      ST_INIT_MRS: if (tmr_zero) begin
        st_n     = ST_INIT_REF;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(REF_COUNT - 1);
      end
      ST_INIT_REF:  if (tmr_zero) st_n = ST_READY;
      ST_READY:     if (trig) st_n = ST_DRAIN;
      ST_DRAIN:     if (!busy) st_n = ST_SR_PRE;
      ST_SR_PRE:    st_n = ST_SR_ENTER;
      ST_SR_ENTER:  st_n = ST_SELF_REF;
      ST_SELF_REF:  if (exit_req) st_n = ST_SR_EXIT;
      ST_SR_EXIT: begin
        if (exit_dly == '0) begin
          st_n = ST_READY;
        end else begin
          st_n     = ST_EXIT_WAIT;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(exit_dly) - CNT_W'(1);
        end
      end
      ST_EXIT_WAIT: if (tmr_zero) st_n = ST_READY;
      default:      st_n = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_OFF;
      byp_q <= 1'b0;
      cke   <= 1'b0;
      cmd   <= CMD_NOP;
      ready <= 1'b0;
    end else begin
      st_q  <= st_n;
      if (st_q == ST_OFF && pwr_start) byp_q <= bypass;
      cke   <= !(st_n == ST_OFF || st_n == ST_SELF_REF);
      ready <= (st_n == ST_READY);
      case (st_n)
        ST_INIT_PRE, ST_SR_PRE: cmd <= CMD_PREA;
        ST_INIT_MRS:            cmd <= CMD_MRS;
        ST_INIT_REF:            cmd <= CMD_REF;
        ST_SR_ENTER:            cmd <= CMD_SRE;
        ST_SR_EXIT:             cmd <= CMD_SRX;
        default:                cmd <= CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/dram_sr_sequencer.sv
module dram_sr_sequencer #(
  parameter int INIT_WAIT   = 16,
  parameter int BYPASS_WAIT = 200,
  parameter int MRS_COUNT   = 4,
  parameter int REF_COUNT   = 2,
  parameter int DLY_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_irq_sr_en,
  input  logic             cfg_force_sr,
  input  logic             cfg_init_bypass,
  input  logic [DLY_W-1:0] cfg_exit_dly,
  input  logic             irq_out_in,
  input  logic             pwr_start,
  input  logic             sr_exit_req,
  input  logic             busy_in,
  output logic             dram_cke,
  output logic [2:0]       dram_cmd,
  output logic             traffic_ready
);
  import srq_pkg::*;

  localparam int LONG_WAIT = (BYPASS_WAIT > INIT_WAIT) ? BYPASS_WAIT : INIT_WAIT;
  localparam int DLY_MAX   = (1 << DLY_W) - 1;
  localparam int BURST_MAX = (MRS_COUNT > REF_COUNT) ? MRS_COUNT : REF_COUNT;
  localparam int MAX_A     = (LONG_WAIT > DLY_MAX) ? LONG_WAIT : DLY_MAX;
  localparam int CNT_MAX   = (MAX_A > BURST_MAX) ? MAX_A : BURST_MAX;
  localparam int CNT_W     = $clog2(CNT_MAX + 1);

  logic             irq_rise, force_rise, trig;
  logic             tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  dram_cmd_e        cmd_e;

  srq_sync_rise #(.STAGES(SYNC_STAGES)) u_irq_edge (
    .clk(clk), .rst(rst), .d(irq_out_in), .rise(irq_rise)
  );

  srq_sync_rise #(.STAGES(0)) u_force_edge (
    .clk(clk), .rst(rst), .d(cfg_force_sr), .rise(force_rise)
  );

  assign trig = (cfg_irq_sr_en & irq_rise) | force_rise;

  srq_timer #(.W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  srq_seq_fsm #(
    .INIT_WAIT(INIT_WAIT), .BYPASS_WAIT(BYPASS_WAIT), .MRS_COUNT(MRS_COUNT),
    .REF_COUNT(REF_COUNT), .DLY_W(DLY_W), .CNT_W(CNT_W)
  ) u_fsm (
    .clk(clk), .rst(rst), .pwr_start(pwr_start), .bypass(cfg_init_bypass),
    .trig(trig), .busy(busy_in), .exit_req(sr_exit_req), .exit_dly(cfg_exit_dly),
    .tmr_zero(tmr_zero), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .cke(dram_cke), .cmd(cmd_e), .ready(traffic_ready)
  );

  assign dram_cmd = cmd_e;
endmodule

// File: rtl/srq_checker.sv
module srq_checker (
  input logic       clk,
  input logic       rst,
  input logic       cke,
  input logic [2:0] cmd,
  input logic       ready,
  input logic       exit_req,
  input logic       pwr_start
);
  import srq_pkg::*;

  // R1
  cke_low_nop_chk: assert property (@(posedge clk) disable iff (rst)
    !cke |-> (cmd == CMD_NOP));

  // R11
  ready_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ready |-> (cke && cmd == CMD_NOP));

  // R7
  sre_after_prea_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_SRE) |-> ($past(cmd) == CMD_PREA));

  // R7
  cke_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_SRE) |=> !cke);

  // R8
  cke_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cke) |-> ($past(exit_req) || $past(pwr_start)));

  // R9
  srx_from_sr_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_SRX) |-> (cke && !$past(cke)));
endmodule

bind dram_sr_sequencer srq_checker u_srq_checker (
  .clk(clk), .rst(rst), .cke(dram_cke), .cmd(dram_cmd), .ready(traffic_ready),
  .exit_req(sr_exit_req), .pwr_start(pwr_start)
);

// File: tb/dram_sr_sequencer_test.sv
`timescale 1ns/1ps
module dram_sr_sequencer_test;
  localparam int INIT_W = 16;
  localparam int BYP_W  = 200;
  localparam int N_MRS  = 4;
  localparam int N_REF  = 2;
  localparam int DW     = 4;
  localparam int C_NOP = 0, C_PREA = 1, C_SRE = 2, C_SRX = 3, C_MRS = 4, C_REF = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_irq_sr_en = 1'b1, cfg_force_sr = 1'b0, cfg_init_bypass = 1'b0;
  logic [DW-1:0] cfg_exit_dly = '0;
  logic irq_out_in = 1'b0, pwr_start = 1'b0, sr_exit_req = 1'b0, busy_in = 1'b0;
  logic dram_cke, traffic_ready;
  logic [2:0] dram_cmd;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2.5 clk = ~clk;

  dram_sr_sequencer #(
    .INIT_WAIT(INIT_W), .BYPASS_WAIT(BYP_W), .MRS_COUNT(N_MRS),
    .REF_COUNT(N_REF), .DLY_W(DW), .SYNC_STAGES(2)
  ) uut (
    .clk(clk), .rst(rst), .cfg_irq_sr_en(cfg_irq_sr_en), .cfg_force_sr(cfg_force_sr),
    .cfg_init_bypass(cfg_init_bypass), .cfg_exit_dly(cfg_exit_dly),
    .irq_out_in(irq_out_in), .pwr_start(pwr_start), .sr_exit_req(sr_exit_req),
    .busy_in(busy_in), .dram_cke(dram_cke), .dram_cmd(dram_cmd),
    .traffic_ready(traffic_ready)
  );

  always @(negedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      checks++; fails++;
      $display("FAIL watchdog (all requirements): actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic int exp_init(input int idx, input bit byp);
    if (byp || idx < INIT_W) return C_NOP;
    if (idx == INIT_W) return C_PREA;
    if (idx <= INIT_W + N_MRS) return C_MRS;
    return C_REF;
  endfunction

  task automatic do_reset();
    rst = 1'b1; irq_out_in = 1'b0; cfg_force_sr = 1'b0; busy_in = 1'b0;
    repeat (4) tick();
    rst = 1'b0;
    tick();
  endtask

  task automatic power_up(input bit byp, input string req);
    int n, bad, len;
    n = 0; bad = 0;
    cfg_init_bypass = byp;
    pwr_start = 1'b1;
    tick();
    pwr_start = 1'b0;
    chk(dram_cke == 1'b1, req, dram_cke, 1);
    while (!traffic_ready && n < 1000) begin
      if (dram_cmd != 3'(exp_init(n, byp)) || !dram_cke) bad++;
      n++;
      tick();
    end
    len = byp ? BYP_W : INIT_W + 1 + N_MRS + N_REF;
    chk(n == len, req, n, len);
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic enter_sr(input bit use_irq, input int b);
    int lat, i, len, bad, exp_lat;
    int seq [0:127];
    busy_in = (b > 0);
    if (use_irq) irq_out_in = 1'b1; else cfg_force_sr = 1'b1;
    tick(); lat = 1;
    while (traffic_ready && lat < 20) begin tick(); lat++; end
    exp_lat = use_irq ? 3 : 1;
    chk(lat == exp_lat, use_irq ? "R4 irq latency" : "R5 force latency", lat, exp_lat);
    i = 0; bad = 0;
    while (dram_cke && i < 100) begin
      seq[i] = int'(dram_cmd);
      if (traffic_ready) bad++;
      if (i == b - 1) busy_in = 1'b0;
      tick();
      i++;
    end
    len = ((b > 1) ? b : 1) + 2;
    chk(i == len, "R6 drain length", i, len);
    chk(bad == 0, "R6 ready low during entry", bad, 0);
    bad = 0;
    for (int k = 0; k < len - 2 && k < i; k++) if (seq[k] != C_NOP) bad++;
    chk(bad == 0, "R6 NOP while draining", bad, 0);
    if (i >= 2) begin
      chk(seq[i-2] == C_PREA, "R7 precharge before entry", seq[i-2], C_PREA);
      chk(seq[i-1] == C_SRE, "R7 entry command", seq[i-1], C_SRE);
    end
    chk(dram_cke == 1'b0 && dram_cmd == 3'(C_NOP), "R7 cke low after entry",
        dram_cke, 0);
  endtask

  task automatic sr_hold(input int n, input bit toggle);
    int bad;
    bad = 0;
    for (int k = 0; k < n; k++) begin
      if (toggle) begin
        irq_out_in   = 1'($urandom % 2);
        cfg_force_sr = 1'($urandom % 2);
      end
      tick();
      if (dram_cke || traffic_ready || dram_cmd != 3'(C_NOP)) bad++;
    end
    chk(bad == 0, "R8 triggers ignored in self-refresh", bad, 0);
  endtask

  task automatic exit_sr(input int dly);
    int w, bad;
    cfg_exit_dly = DW'(dly);
    sr_exit_req = 1'b1;
    tick();
    sr_exit_req = 1'b0;
    chk(dram_cke && dram_cmd == 3'(C_SRX), "R9 exit command", int'(dram_cmd), C_SRX);
    w = 0; bad = 0;
    tick();
    while (!traffic_ready && w < 40) begin
      if (dram_cmd != 3'(C_NOP) || !dram_cke) bad++;
      w++;
      tick();
    end
    chk(w == dly, "R9 exit delay", w, dly);
    chk(bad == 0, "R9 NOP during exit delay", bad, 0);
    chk(dram_cke && dram_cmd == 3'(C_NOP), "R11 ready quiet", int'(dram_cmd), C_NOP);
  endtask

  initial begin
    int bad;
    void'($urandom(32'd24681));
    do_reset();
    // R1 reset state and idle before power-up
    bad = 0;
    for (int k = 0; k < 5; k++) begin
      if (dram_cke || traffic_ready || dram_cmd != 3'(C_NOP)) bad++;
      tick();
    end
    chk(bad == 0, "R1 idle after reset", bad, 0);

    power_up(1'b0, "R2 normal init");

    // R4 disabled interrupt line has no effect
    cfg_irq_sr_en = 1'b0;
    irq_out_in = 1'b1;
    repeat (4) tick();
    irq_out_in = 1'b0;
    bad = 0;
    repeat (8) begin tick(); if (!traffic_ready) bad++; end
    chk(bad == 0, "R4 irq ignored when disabled", bad, 0);
    cfg_irq_sr_en = 1'b1;
    repeat (3) tick();

    // directed: irq entry with no busy, exit delay 0
    enter_sr(1'b1, 0);
    irq_out_in = 1'b0;
    sr_hold(12, 1'b1);
    irq_out_in = 1'b0; cfg_force_sr = 1'b0;
    sr_hold(4, 1'b0);
    exit_sr(0);
    repeat (3) tick();

    // directed: force entry with long drain, max exit delay
    enter_sr(1'b0, 4);
    cfg_force_sr = 1'b0;
    sr_hold(3, 1'b0);
    exit_sr((1 << DW) - 1);
    repeat (3) tick();

    // R10 held trigger gives one entry only
    enter_sr(1'b1, 0);
    sr_hold(5, 1'b0);
    exit_sr(2);
    bad = 0;
    repeat (20) begin tick(); if (!traffic_ready) bad++; end
    chk(bad == 0, "R10 no second entry while line held", bad, 0);
    irq_out_in = 1'b0;
    repeat (3) tick();

    // random rounds
    for (int r = 0; r < 8; r++) begin
      enter_sr(1'($urandom % 2), int'($urandom % 5));
      irq_out_in = 1'b0; cfg_force_sr = 1'b0;
      sr_hold(2 + int'($urandom % 4), 1'b1);
      irq_out_in = 1'b0; cfg_force_sr = 1'b0;
      sr_hold(3, 1'b0);
      exit_sr(int'($urandom % 16));
      repeat (3) tick();
    end

    // bypass power-up after a fresh reset
    do_reset();
    chk(!dram_cke && !traffic_ready, "R1 reset clears state", dram_cke, 0);
    power_up(1'b1, "R3 bypass wait");
    enter_sr(1'b0, 1);
    cfg_force_sr = 1'b0;
    sr_hold(3, 1'b0);
    exit_sr(5);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule